// File: doc/BRIEF.md
# Five-Level Vectored Interrupt Controller with Automatic Entry Sequence

This block gathers thirteen interrupt request lines, keeps one pending flag per line, and sorts the lines into five priority levels. At a processor instruction boundary it picks a single winning source. The order between levels comes from a small programmable field, and the order inside a level is fixed, with the lower vector address first. Once a source wins, the controller clears the global interrupt enable. It then uses its own memory port to save the return context on the stack and to read the two-byte handler address from the vector table. When the address is ready it hands it to the processor with a one-cycle start pulse.

Nine sources each own a two-byte vector slot. The remaining four share one slot, and for that slot the software handler reads the pending flags to find out which line fired. The controller never clears pending flags of the shared slot on its own. Instruction execution, the return-from-handler path and the request-raising peripherals sit outside the block.

Top module: `intc_top`

## Requirements
- R1: A high `req_i[s]` sets pending flag s on the next edge, and `pend_clr_i[s]` clears it. When both are high on the same edge, the flag ends set. `pend_o` shows the flags and is all zero after reset.
- R2: A pending source can be granted only when `ie_o` is 1 and the `lvl_mask_i` bit of its level is 1. The level map is: sources 0–1 → level 0, 2–3 → level 1, 4–5 → level 2, 6–8 → level 3, 9–12 → level 4.
- R3: Between levels, `prio_cfg_i` sets the order, highest first. Values 0–4 rotate upward starting at level k (k, k+1, … mod 5). Value 5 gives 4,3,2,1,0, value 6 gives 2,1,0,4,3, and value 7 gives 0,4,3,2,1.
- R4: Within one level, the eligible source with the lowest vector address wins. Source s<9 has vector 2·s, and sources 9–12 share vector 0x0012.
- R5: Arbitration happens only on an edge where `boundary_i` is 1 and the block is idle. No new grant is taken while `busy_o` is 1.
- R6: A grant clears `ie_o` on the same edge, even if a software enable write arrives in that cycle.
- R7: After a grant, three stack writes follow on consecutive cycles, one byte each. They go to SP−1 with PC[7:0], then SP−2 with PC[15:8], then SP−3 with the flags byte. SP, PC and flags are sampled on the grant edge.
- R8: Next come two reads, first at the vector address and then at vector+1, with read data returned one cycle after each read. The handler address is {byte at vector, byte at vector+1}.
- R9: A grant clears the winner's pending flag when the winner owns its vector (sources 0–8). Flags of sources 9–12 are left untouched.
- R10: The grant edge starts a fixed 7-cycle busy window. Its last cycle raises `start_o` for exactly one cycle, together with `start_pc_o` and `sp_o` = SP−3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 13 | Request lines, one per source |
| pend_clr_i | input | 13 | Software clear of pending flags |
| ie_wr_i | input | 1 | Software write strobe for the global enable |
| ie_wdata_i | input | 1 | Value written to the global enable |
| lvl_mask_i | input | 5 | Per-level enable mask |
| prio_cfg_i | input | 3 | Level-order select |
| boundary_i | input | 1 | Instruction boundary from the processor |
| pc_i | input | 16 | Return program counter |
| flags_i | input | 8 | Status flags to save |
| sp_i | input | 16 | Current stack pointer |
| mem_rdata_i | input | 8 | Read data, one cycle after a read |
| pend_o | output | 13 | Pending flags |
| ie_o | output | 1 | Global interrupt enable |
| busy_o | output | 1 | Entry sequence in progress |
| mem_addr_o | output | 16 | Memory address |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_wdata_o | output | 8 | Memory write data |
| start_o | output | 1 | Handler start pulse |
| start_pc_o | output | 16 | Handler address |
| sp_o | output | 16 | Stack pointer after the pushes |

## Verification
The bench runs all eight order selections, each twice. The second run masks the top level so that the runner-up level has to win. A controller with a wrong rotation or reversal would read the vector of the wrong level. It also covers two sources in one level, a set and a clear on the same edge, and an enable write landing on the grant edge. A fault there would pick the higher index, drop a fresh request, or leave interrupts enabled inside the handler. Boundary is held high across a whole sequence while a higher source arrives, which exposes a design that re-arbitrates while busy. The shared vector is checked for its flags staying set, which catches a design that clears them as it does for owned vectors. Stack bytes and the two-byte handler address are compared against a bench memory, so swapped push order or swapped vector bytes show up.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;

    localparam int NSRC = 13;
    localparam int NLVL = 5;
    localparam int NOWN = 9;
    localparam int AW   = 16;
    localparam int DW   = 8;
    localparam int CFGW = 3;
    localparam int SRCW = $clog2(NSRC);
    localparam int LVLW = $clog2(NLVL);

    localparam logic [AW-1:0] VEC_BASE   = '0;
    localparam logic [AW-1:0] VEC_SHARED = VEC_BASE + AW'(2 * NOWN);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PCL,
        ST_PUSH_PCH,
        ST_PUSH_FLG,
        ST_VEC_HI,
        ST_VEC_LO,
        ST_CAP_LO,
        ST_LAUNCH
    } seq_st_e;

    typedef struct packed {
        logic [SRCW-1:0] src;
        logic [AW-1:0]   vec;
    } winner_t;

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [DW-1:0] flags;
        logic [AW-1:0] sp;
    } ctx_t;

    // Level of each source.
    function automatic logic [LVLW-1:0] src_level(input int s);
        if (s < 2)      return LVLW'(0);
        else if (s < 4) return LVLW'(1);
        else if (s < 6) return LVLW'(2);
        else if (s < 9) return LVLW'(3);
        else            return LVLW'(4);
    endfunction

    // Vector address: own two-byte slot, or the common slot.
    function automatic logic [AW-1:0] src_vector(input int s);
        if (s < NOWN) return VEC_BASE + AW'(2 * s);
        else          return VEC_SHARED;
    endfunction

    // Level found at rank position pos (0 = served first) for a config.
    function automatic logic [LVLW-1:0] rank_level(input logic [CFGW-1:0] cfg,
                                                   input int pos);
        int c;
        c = int'(cfg);
        if (c < NLVL)  return LVLW'((c + pos) % NLVL);
        else if (c == 5) return LVLW'(4 - pos);
        else if (c == 6) return LVLW'((2 - pos + NLVL) % NLVL);
        else             return LVLW'((NLVL - pos) % NLVL);
    endfunction

endpackage

// File: rtl/intc_pend_bank.sv
`timescale 1ns/1ps
module intc_pend_bank #(
    parameter int N = intc_pkg::NSRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] sw_clr_i,
    input  logic [N-1:0] hw_clr_i,
    output logic [N-1:0] pend_o
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk) begin
            if (rst)
                flag_q <= 1'b0;
            else if (set_i[i])
                flag_q <= 1'b1;
            else if (sw_clr_i[i] || hw_clr_i[i])
                flag_q <= 1'b0;
        end
        assign pend_o[i] = flag_q;
    end

endmodule

// File: rtl/intc_level_arb.sv
`timescale 1ns/1ps
module intc_level_arb
    import intc_pkg::*;
#(
    parameter int N = NSRC,
    parameter int L = NLVL
) (
    input  logic [N-1:0]    pend_i,
    input  logic            ie_i,
    input  logic [L-1:0]    lvl_mask_i,
    input  logic [CFGW-1:0] cfg_i,
    output logic            valid_o,
    output winner_t         win_o
);

    logic [N-1:0] elig;

    for (genvar s = 0; s < N; s++) begin : g_elig
        assign elig[s] = pend_i[s] & ie_i & lvl_mask_i[src_level(s)];
    end

    always_comb begin
        logic found;
        logic [LVLW-1:0] lv;
        found = 1'b0;
        win_o = '0;
        for (int pos = 0; pos < L; pos++) begin
            lv = rank_level(cfg_i, pos);
            for (int s = 0; s < N; s++) begin
                if (!found && elig[s] && (src_level(s) == lv)) begin
                    found     = 1'b1;
                    win_o.src = SRCW'(s);
                    win_o.vec = src_vector(s);
                end
            end
        end
        valid_o = found;
    end

endmodule

// File: rtl/intc_entry_fsm.sv
`timescale 1ns/1ps
module intc_entry_fsm
    import intc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          go_i,
    input  winner_t       win_i,
    input  ctx_t          ctx_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          busy_o,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_we_o,
    output logic          mem_re_o,
    output logic [DW-1:0] mem_wdata_o,
    output logic          start_o,
    output logic [AW-1:0] start_pc_o,
    output logic [AW-1:0] sp_o
);

    seq_st_e       st_q, st_n;
    winner_t       win_q;
    ctx_t          ctx_q;
    logic [DW-1:0] hi_q, lo_q;

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_IDLE:     if (go_i) st_n = ST_PUSH_PCL;
            ST_PUSH_PCL: st_n = ST_PUSH_PCH;
            ST_PUSH_PCH: st_n = ST_PUSH_FLG;
            ST_PUSH_FLG: st_n = ST_VEC_HI;
            ST_VEC_HI:   st_n = ST_VEC_LO;
            ST_VEC_LO:   st_n = ST_CAP_LO;
            ST_CAP_LO:   st_n = ST_LAUNCH;
            ST_LAUNCH:   st_n = ST_IDLE;
            default:     st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            win_q <= '0;
            ctx_q <= '0;
            hi_q  <= '0;
            lo_q  <= '0;
        end else begin
            st_q <= st_n;
            if (st_q == ST_IDLE && go_i) begin
                win_q <= win_i;
                ctx_q <= ctx_i;
            end
            if (st_q == ST_VEC_LO) hi_q <= mem_rdata_i;
            if (st_q == ST_CAP_LO) lo_q <= mem_rdata_i;
        end
    end

    always_comb begin
        mem_addr_o  = '0;
        mem_we_o    = 1'b0;
        mem_re_o    = 1'b0;
        mem_wdata_o = '0;
        unique case (st_q)
            ST_PUSH_PCL: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = ctx_q.sp - AW'(1);
                mem_wdata_o = ctx_q.pc[DW-1:0];
            end
            ST_PUSH_PCH: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = ctx_q.sp - AW'(2);
                mem_wdata_o = ctx_q.pc[AW-1:DW];
            end
            ST_PUSH_FLG: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = ctx_q.sp - AW'(3);
                mem_wdata_o = ctx_q.flags;
            end
            ST_VEC_HI: begin
                mem_re_o   = 1'b1;
                mem_addr_o = win_q.vec;
            end
            ST_VEC_LO: begin
                mem_re_o   = 1'b1;
                mem_addr_o = win_q.vec + AW'(1);
            end
            default: ;
        endcase
    end

    assign busy_o     = (st_q != ST_IDLE);
    assign start_o    = (st_q == ST_LAUNCH);
    assign start_pc_o = {hi_q, lo_q};
    assign sp_o       = ctx_q.sp - AW'(3);

endmodule

// File: rtl/intc_top.sv
`timescale 1ns/1ps
module intc_top
    import intc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] req_i,
    input  logic [NSRC-1:0] pend_clr_i,
    input  logic            ie_wr_i,
    input  logic            ie_wdata_i,
    input  logic [NLVL-1:0] lvl_mask_i,
    input  logic [CFGW-1:0] prio_cfg_i,
    input  logic            boundary_i,
    input  logic [AW-1:0]   pc_i,
    input  logic [DW-1:0]   flags_i,
    input  logic [AW-1:0]   sp_i,
    input  logic [DW-1:0]   mem_rdata_i,
    output logic [NSRC-1:0] pend_o,
    output logic            ie_o,
    output logic            busy_o,
    output logic [AW-1:0]   mem_addr_o,
    output logic            mem_we_o,
    output logic            mem_re_o,
    output logic [DW-1:0]   mem_wdata_o,
    output logic            start_o,
    output logic [AW-1:0]   start_pc_o,
    output logic [AW-1:0]   sp_o
);

    logic            arb_valid;
    winner_t         arb_win;
    logic            grant;
    logic [NSRC-1:0] auto_clr;
    logic            ie_q;
    ctx_t            ctx;

    intc_pend_bank #(.N(NSRC)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .set_i    (req_i),
        .sw_clr_i (pend_clr_i),
        .hw_clr_i (auto_clr),
        .pend_o   (pend_o)
    );

    intc_level_arb #(.N(NSRC), .L(NLVL)) u_arb (
        .pend_i     (pend_o),
        .ie_i       (ie_q),
        .lvl_mask_i (lvl_mask_i),
        .cfg_i      (prio_cfg_i),
        .valid_o    (arb_valid),
        .win_o      (arb_win)
    );

    assign grant = boundary_i && arb_valid && !busy_o;

    always_comb begin
        auto_clr = '0;
        if (grant && (int'(arb_win.src) < NOWN))
            auto_clr[arb_win.src] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)          ie_q <= 1'b0;
        else if (grant)   ie_q <= 1'b0;
        else if (ie_wr_i) ie_q <= ie_wdata_i;
    end
    assign ie_o = ie_q;

    assign ctx = '{pc: pc_i, flags: flags_i, sp: sp_i};

    intc_entry_fsm u_seq (
        .clk         (clk),
        .rst         (rst),
        .go_i        (grant),
        .win_i       (arb_win),
        .ctx_i       (ctx),
        .mem_rdata_i (mem_rdata_i),
        .busy_o      (busy_o),
        .mem_addr_o  (mem_addr_o),
        .mem_we_o    (mem_we_o),
        .mem_re_o    (mem_re_o),
        .mem_wdata_o (mem_wdata_o),
        .start_o     (start_o),
        .start_pc_o  (start_pc_o),
        .sp_o        (sp_o)
    );

endmodule

// File: rtl/intc_chk.sv
`timescale 1ns/1ps
module intc_chk (
    input logic        clk,
    input logic        rst,
    input logic        boundary_i,
    input logic        ie_o,
    input logic        busy_o,
    input logic [15:0] mem_addr_o,
    input logic        mem_we_o,
    input logic        mem_re_o,
    input logic        start_o
);

    // R6
    grant_clears_ie_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> !ie_o);

    // R5
    grant_needs_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(boundary_i));

    // R7
    push_descends_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) - 16'd1));

    // R7
    no_rw_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> !mem_re_o);

    // R8
    vec_bytes_adjacent_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_re_o && $past(mem_re_o)) |-> (mem_addr_o == $past(mem_addr_o) + 16'd1));

    // R10
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o);

    // R10
    start_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start_o |-> busy_o);

endmodule

bind intc_top intc_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .boundary_i (boundary_i),
    .ie_o       (ie_o),
    .busy_o     (busy_o),
    .mem_addr_o (mem_addr_o),
    .mem_we_o   (mem_we_o),
    .mem_re_o   (mem_re_o),
    .start_o    (start_o)
);

// File: tb/tb_intc_top.sv
`timescale 1ns/1ps
module tb_intc_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] req_i = '0, pend_clr_i = '0;
    logic        ie_wr_i = 1'b0, ie_wdata_i = 1'b0;
    logic [4:0]  lvl_mask_i = 5'h1F;
    logic [2:0]  prio_cfg_i = '0;
    logic        boundary_i = 1'b0;
    logic [15:0] pc_i = 16'h1234;
    logic [7:0]  flags_i = 8'hA5;
    logic [15:0] sp_i = 16'h00F0;
    logic [7:0]  mem_rdata_i = '0;
    logic [12:0] pend_o;
    logic        ie_o, busy_o, mem_we_o, mem_re_o, start_o;
    logic [15:0] mem_addr_o, start_pc_o, sp_o;
    logic [7:0]  mem_wdata_o;

    always #2.5 clk = ~clk;

    intc_top dut (.*);

    int checks = 0, errors = 0;
    logic [7:0] mem [256];

    // Bench memory: write on edge, read data one cycle later.
    always @(posedge clk) begin
        if (mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
        if (mem_re_o) mem_rdata_i <= mem[mem_addr_o[7:0]];
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int ord [8][5] = '{'{0,1,2,3,4}, '{1,2,3,4,0}, '{2,3,4,0,1}, '{3,4,0,1,2},
                       '{4,0,1,2,3}, '{4,3,2,1,0}, '{2,1,0,4,3}, '{0,4,3,2,1}};

    function automatic int lvl_of(int s);
        case (s)
            0, 1:        return 0;
            2, 3:        return 1;
            4, 5:        return 2;
            6, 7, 8:     return 3;
            default:     return 4;
        endcase
    endfunction

    function automatic logic [15:0] vec_of(int s);
        return (s < 9) ? 16'(2 * s) : 16'h0012;
    endfunction

    logic [12:0] m_pend;
    bit          m_ie;
    int          m_step;
    logic [15:0] m_pc, m_sp, m_vec;
    logic [7:0]  m_flags;

    always @(posedge clk) begin
        if (rst) begin
            m_pend = '0; m_ie = 0; m_step = 0;
            m_pc = '0; m_sp = '0; m_vec = '0; m_flags = '0;
        end else begin
            int win;
            win = -1;
            if (m_step == 0 && boundary_i && m_ie) begin
                for (int p = 0; p < 5; p++)
                    for (int s = 0; s < 13; s++)
                        if (win < 0 && m_pend[s] && lvl_mask_i[lvl_of(s)] && lvl_of(s) == ord[prio_cfg_i][p])
                            win = s;
            end
            for (int s = 0; s < 13; s++) begin
                if (req_i[s]) m_pend[s] = 1'b1;
                else if (pend_clr_i[s] || (s == win && s < 9)) m_pend[s] = 1'b0;
            end
            if (win >= 0) m_ie = 0;
            else if (ie_wr_i) m_ie = ie_wdata_i;
            if (m_step == 7) m_step = 0;
            else if (m_step != 0) m_step++;
            else if (win >= 0) begin
                m_step = 1; m_pc = pc_i; m_sp = sp_i; m_flags = flags_i; m_vec = vec_of(win);
            end
        end
    end

    logic [15:0] cap_vec, cap_pc, cap_sp;
    int n_starts = 0;

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            chk(pend_o == m_pend, "R1 pending", 32'(pend_o), 32'(m_pend));
            chk(ie_o == m_ie, "R6 enable", 32'(ie_o), 32'(m_ie));
            chk(busy_o == (m_step != 0), "R5 busy", 32'(busy_o), 32'(m_step != 0));
            chk(mem_we_o == (m_step >= 1 && m_step <= 3), "R7 write strobe", 32'(mem_we_o), 32'(m_step));
            chk(mem_re_o == (m_step == 4 || m_step == 5), "R8 read strobe", 32'(mem_re_o), 32'(m_step));
            chk(start_o == (m_step == 7), "R10 start", 32'(start_o), 32'(m_step));
            case (m_step)
                1: begin
                    chk(mem_addr_o == m_sp - 16'd1, "R7 addr pcl", 32'(mem_addr_o), 32'(m_sp - 16'd1));
                    chk(mem_wdata_o == m_pc[7:0], "R7 data pcl", 32'(mem_wdata_o), 32'(m_pc[7:0]));
                end
                2: begin
                    chk(mem_addr_o == m_sp - 16'd2, "R7 addr pch", 32'(mem_addr_o), 32'(m_sp - 16'd2));
                    chk(mem_wdata_o == m_pc[15:8], "R7 data pch", 32'(mem_wdata_o), 32'(m_pc[15:8]));
                end
                3: begin
                    chk(mem_addr_o == m_sp - 16'd3, "R7 addr flags", 32'(mem_addr_o), 32'(m_sp - 16'd3));
                    chk(mem_wdata_o == m_flags, "R7 data flags", 32'(mem_wdata_o), 32'(m_flags));
                end
                4: begin
                    chk(mem_addr_o == m_vec, "R8 vec hi addr", 32'(mem_addr_o), 32'(m_vec));
                    cap_vec = mem_addr_o;
                end
                5: chk(mem_addr_o == m_vec + 16'd1, "R8 vec lo addr", 32'(mem_addr_o), 32'(m_vec + 16'd1));
                7: begin
                    chk(start_pc_o == {mem[m_vec[7:0]], mem[8'(m_vec[7:0] + 8'd1)]}, "R8 handler address",
                        32'(start_pc_o), 32'({mem[m_vec[7:0]], mem[8'(m_vec[7:0] + 8'd1)]}));
                    chk(sp_o == m_sp - 16'd3, "R10 sp out", 32'(sp_o), 32'(m_sp - 16'd3));
                    cap_pc = start_pc_o; cap_sp = sp_o; n_starts++;
                end
                default: ;
            endcase
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_req(logic [12:0] m);
        req_i = m; tick(); req_i = '0;
    endtask

    task automatic clear_all();
        pend_clr_i = '1; tick(); pend_clr_i = '0;
    endtask

    task automatic set_ie(bit v);
        ie_wr_i = 1'b1; ie_wdata_i = v; tick(); ie_wr_i = 1'b0;
    endtask

    task automatic do_boundary(logic [15:0] exp_vec, string tag);
        cap_vec = 16'hFFFF;
        boundary_i = 1'b1; tick(); boundary_i = 1'b0;
        tick(8);
        chk(cap_vec == exp_vec, tag, 32'(cap_vec), 32'(exp_vec));
    endtask

    logic [15:0] top_vec [8] = '{16'h00, 16'h04, 16'h08, 16'h0C, 16'h12, 16'h12, 16'h08, 16'h00};
    logic [15:0] sec_vec [8] = '{16'h04, 16'h08, 16'h0C, 16'h12, 16'h00, 16'h0C, 16'h04, 16'h12};
    int          top_lvl [8] = '{0, 1, 2, 3, 4, 4, 2, 0};

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = 8'(a * 7 + 3);
        tick(4);
        rst = 1'b0;
        tick();
        // Reset state
        chk(pend_o == 13'h0, "R1 reset pending", 32'(pend_o), 0);
        chk(ie_o == 1'b0, "R6 reset enable", 32'(ie_o), 0);
        chk(busy_o == 1'b0, "R10 reset busy", 32'(busy_o), 0);

        // R1: set, clear, set-wins
        pulse_req(13'h0008);
        chk(pend_o == 13'h0008, "R1 set", 32'(pend_o), 32'h8);
        pend_clr_i = 13'h0008; tick(); pend_clr_i = '0;
        chk(pend_o == 13'h0, "R1 clear", 32'(pend_o), 0);
        req_i = 13'h0020; pend_clr_i = 13'h0020; tick(); req_i = '0; pend_clr_i = '0;
        chk(pend_o == 13'h0020, "R1 set wins", 32'(pend_o), 32'h20);
        clear_all();

        // R2: gating by enable and level mask
        pulse_req(13'h0001);
        do_boundary(16'hFFFF, "R2 disabled no grant");
        chk(busy_o == 1'b0, "R2 idle when disabled", 32'(busy_o), 0);
        set_ie(1'b1);
        lvl_mask_i = 5'b11110;
        do_boundary(16'hFFFF, "R2 masked no grant");
        lvl_mask_i = 5'b11111;
        do_boundary(16'h0000, "R2 unmasked grant");
        chk(pend_o[0] == 1'b0, "R9 own vector cleared", 32'(pend_o), 0);
        chk(ie_o == 1'b0, "R6 enable cleared", 32'(ie_o), 0);
        chk(mem[8'hEF] == 8'h34 && mem[8'hEE] == 8'h12 && mem[8'hED] == 8'hA5, "R7 stack image",
            {8'h0, mem[8'hEF], mem[8'hEE], mem[8'hED]}, 32'h3412A5);
        chk(cap_pc == {8'(0 * 7 + 3), 8'(1 * 7 + 3)}, "R8 handler from table", 32'(cap_pc), 32'h030A);
        chk(cap_sp == 16'h00ED, "R10 sp after push", 32'(cap_sp), 32'hED);

        // R3: every order selection, top and runner-up level
        for (int cfg = 0; cfg < 8; cfg++) begin
            for (int sec = 0; sec < 2; sec++) begin
                clear_all();
                pulse_req(13'h0255); // sources 0,2,4,6,9
                prio_cfg_i = 3'(cfg);
                lvl_mask_i = sec ? ~(5'(1) << top_lvl[cfg]) : 5'h1F;
                set_ie(1'b1);
                do_boundary(sec ? sec_vec[cfg] : top_vec[cfg], sec ? "R3 runner-up level" : "R3 top level");
            end
        end
        lvl_mask_i = 5'h1F;
        prio_cfg_i = 3'd0;

        // R4 / R9: inside-level ordering and shared vector flags
        clear_all();
        pulse_req(13'h0180); // sources 7,8
        set_ie(1'b1);
        do_boundary(16'h000E, "R4 lowest vector in level");
        chk(pend_o == 13'h0100, "R9 own cleared other kept", 32'(pend_o), 32'h100);
        set_ie(1'b1);
        do_boundary(16'h0010, "R4 next in level");
        clear_all();
        pulse_req(13'h1800); // sources 11,12
        set_ie(1'b1);
        do_boundary(16'h0012, "R4 shared vector");
        chk(pend_o == 13'h1800, "R9 shared flags kept", 32'(pend_o), 32'h1800);
        clear_all();

        // R6: enable write on the grant edge loses
        pulse_req(13'h0004);
        set_ie(1'b1);
        boundary_i = 1'b1; ie_wr_i = 1'b1; ie_wdata_i = 1'b1; tick();
        boundary_i = 1'b0; ie_wr_i = 1'b0;
        chk(ie_o == 1'b0, "R6 grant beats write", 32'(ie_o), 0);
        tick(8);

        // R5: no boundary, no grant; no re-arbitration while busy
        pulse_req(13'h0004);
        set_ie(1'b1);
        tick(3);
        chk(busy_o == 1'b0, "R5 waits for boundary", 32'(busy_o), 0);
        clear_all();
        prio_cfg_i = 3'd3;
        pulse_req(13'h0040); // source 6, level 3 on top
        n_starts = 0;
        boundary_i = 1'b1; tick();
        req_i = 13'h0001; ie_wr_i = 1'b1; ie_wdata_i = 1'b1; tick();
        req_i = '0; ie_wr_i = 1'b0;
        tick(4);
        chk(n_starts == 0 && busy_o == 1'b1, "R5 still first sequence", 32'(n_starts), 0);
        tick(2);
        chk(n_starts == 1 && cap_vec == 16'h000C, "R5 first winner", 32'(cap_vec), 32'hC);
        tick(8);
        boundary_i = 1'b0;
        chk(n_starts == 2 && cap_vec == 16'h0000, "R5 second after idle", 32'(cap_vec), 32'h0);
        tick(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #500us;
        errors++;
        $display("FAIL R10 watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule